// File: doc/BRIEF.md
# Dual-Sided Byte Mailbox

This block is a small register file shared by two bus agents: a host and a management controller. Each agent has its own byte-wide register port with an address, a write strobe, a read strobe and write data. Read data is combinational from the address. Sixteen data bytes are visible to both sides. Each side also has its own status flags, interrupt enables and control register, and drives one level interrupt.

When one side writes a data byte, a matching status flag is set in the other side's status registers. The receiving side can enable interrupts on chosen bytes only, such as the response byte (13) and the attention byte (15). Byte 15 also serves as a flag byte, and one of its bits can carry a reset indication. A separate coarse interrupt status bit in each control register is set by any read or write of a data byte by the peer. An explicit ping from the peer also sets it. Each side can mask this coarse bit away from its interrupt. When a status flag is set and cleared in the same cycle, the set wins.

Top module: `dual_mailbox`

## Requirements
- R1: After reset every offset reads 0x00 from both sides and both interrupt outputs are low.
- R2: Offsets 0x00 to 0x0F are data bytes, written and read identically from either side. Offset 0x0F is an ordinary data byte that software uses as a flag byte.
- R3: If both sides write the same data byte in one cycle, the byte takes the management side's value and both sides' status flags for that byte are set.
- R4: A data write of byte b sets bit b%8 of the peer's status register at offset 0x10 (b<8) or 0x11 (b>=8). The writer's own status registers are unchanged.
- R5: Status registers are write-one-to-clear: a 1 in the written value clears that flag, and a 0 leaves it unchanged.
- R6: Offsets 0x14 and 0x15 are the enable registers for the flags at 0x10 and 0x11. With only bits 7 and 5 of 0x15 enabled, only writes by the peer to bytes 15 and 13 raise the interrupt.
- R7: Control register layout: bit 7 is the coarse interrupt status (write-one-to-clear), bit 1 is the mask, and bit 0 is the ping, which always reads 0. Bit 7 is set by any peer access (read or write) to a data byte.
- R8: While the mask bit is 1, the coarse status still sets but does not drive the interrupt. While it is 0, a set coarse status drives the interrupt.
- R9: Writing control bit 0 sets the peer's coarse status. A single write of 0x03 both pings the peer and masks the writer's own coarse interrupt.
- R10: The interrupt output is registered. It changes on the clock edge after the edge on which its cause was stored.
- R11: The host control register is at 0x13 and the management control register is at 0x12. Each side sees only its own control register: the other one's offset, and offsets 0x16 to 0x1F, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | 5 | Host register offset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (counts as a data access) |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational from h_addr |
| h_irq | output | 1 | Host interrupt, level |
| m_addr | input | 5 | Management register offset |
| m_wr | input | 1 | Management write strobe |
| m_rd | input | 1 | Management read strobe (counts as a data access) |
| m_wdata | input | 8 | Management write data |
| m_rdata | output | 8 | Management read data, combinational from m_addr |
| m_irq | output | 1 | Management interrupt, level |

## Verification
A status flag stored in the wrong bit, or in the writer's own bank, is visible on the very next read of 0x10 or 0x11 from either side, so the bench reads both banks after every data write. An interrupt wrongly decided from the mask or the enables shows one edge after the cause. For that reason the interrupt is sampled both before and after that edge. A lost arbitration or a ping routed to the wrong side appears at once as a wrong read value or as a missing coarse status bit on the peer.

// File: rtl/mbox_pkg.sv
// Package: shared constants for the dual-sided mailbox.
// Assumes byte-wide registers; control bit positions are fixed by software.
package mbox_pkg;
    localparam int BYTE_W   = 8;
    localparam int CTL_IST  = 7;   // coarse interrupt status, W1C
    localparam int CTL_MASK = 1;   // coarse interrupt mask
    localparam int CTL_PING = 0;   // ping toward the peer, reads 0
endpackage

// File: rtl/mbox_data_array.sv
// Module: shared data bytes with write arbitration.
// Both sides may write in one cycle; the management side wins on a clash.
// Also reports which byte each side wrote, for the status logic.
module mbox_data_array #(
    parameter int NUM_BYTES = 16,
    parameter int ADDR_W    = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   h_addr,
    input  logic                                h_wr,
    input  logic [mbox_pkg::BYTE_W-1:0]         h_wdata,
    input  logic [ADDR_W-1:0]                   m_addr,
    input  logic                                m_wr,
    input  logic [mbox_pkg::BYTE_W-1:0]         m_wdata,
    output logic [NUM_BYTES*mbox_pkg::BYTE_W-1:0] bytes_flat,
    output logic [NUM_BYTES-1:0]                h_hit,
    output logic [NUM_BYTES-1:0]                m_hit
);
    localparam int BW = mbox_pkg::BYTE_W;

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        // Decode which byte each side writes this cycle.
        assign h_hit[i] = h_wr && (h_addr == ADDR_W'(i));
        assign m_hit[i] = m_wr && (m_addr == ADDR_W'(i));

        // Store one byte, management side first.
        always_ff @(posedge clk) begin
            if (!rst_n)        bytes_flat[i*BW +: BW] <= '0;
            else if (m_hit[i]) bytes_flat[i*BW +: BW] <= m_wdata;
            else if (h_hit[i]) bytes_flat[i*BW +: BW] <= h_wdata;
        end

        // R3
        mgmt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (h_hit[i] && m_hit[i]) |=> (bytes_flat[i*BW +: BW] == $past(m_wdata)));
    end
endmodule

// File: rtl/mbox_side.sv
// Module: one side's status, enable and control registers plus its interrupt.
// Assumes peer_hit/peer_touch/peer_ping come from the other side's bus in the
// same cycle; set takes priority over write-one-to-clear.
module mbox_side #(
    parameter int NUM_BYTES = 16,
    parameter int ADDR_W    = 5,
    parameter int CTRL_OFS  = 18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr,
    input  logic [mbox_pkg::BYTE_W-1:0] wdata,
    input  logic [NUM_BYTES-1:0]        peer_hit,
    input  logic                        peer_touch,
    input  logic                        peer_ping,
    output logic [mbox_pkg::BYTE_W-1:0] rdata,
    output logic                        ping_out,
    output logic                        irq
);
    import mbox_pkg::*;
    localparam int NSTAT    = NUM_BYTES / BYTE_W;
    localparam int STAT_OFS = NUM_BYTES;
    localparam int IEN_OFS  = NUM_BYTES + NSTAT + 2;

    logic [NUM_BYTES-1:0] stat_q, ien_q, clr;
    logic                 ist_q, mask_q, ctl_wr;

    // Decode write-one-to-clear bits aimed at the status registers.
    always_comb begin
        clr = '0;
        for (int k = 0; k < NSTAT; k++)
            if (wr && addr == ADDR_W'(STAT_OFS + k)) clr[k*BYTE_W +: BYTE_W] = wdata;
    end

    assign ctl_wr   = wr && (addr == ADDR_W'(CTRL_OFS));
    assign ping_out = ctl_wr && wdata[CTL_PING];

    // Status flags: peer writes set, own writes of one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | peer_hit;
    end

    // Interrupt enable registers, written by this side only.
    always_ff @(posedge clk) begin
        if (!rst_n) ien_q <= '0;
        else
            for (int k = 0; k < NSTAT; k++)
                if (wr && addr == ADDR_W'(IEN_OFS + k)) ien_q[k*BYTE_W +: BYTE_W] <= wdata;
    end

    // Control register: mask bit and coarse status with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            ist_q  <= 1'b0;
        end else begin
            if (ctl_wr) mask_q <= wdata[CTL_MASK];
            ist_q <= (ist_q & ~(ctl_wr & wdata[CTL_IST])) | peer_touch | peer_ping;
        end
    end

    // Registered level interrupt from enabled flags and unmasked coarse status.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (|(stat_q & ien_q)) | (ist_q & ~mask_q);
    end

    // Read mux for this side's non-data registers.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NSTAT; k++) begin
            if (addr == ADDR_W'(STAT_OFS + k)) rdata = stat_q[k*BYTE_W +: BYTE_W];
            if (addr == ADDR_W'(IEN_OFS + k))  rdata = ien_q[k*BYTE_W +: BYTE_W];
        end
        if (addr == ADDR_W'(CTRL_OFS)) begin
            rdata[CTL_IST]  = ist_q;
            rdata[CTL_MASK] = mask_q;
        end
    end

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_chk
        // R4
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            peer_hit[i] |=> stat_q[i]);
        // R5
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !peer_hit[i]) |=> !stat_q[i]);
    end

    // R9
    ping_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peer_ping |=> ist_q);

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && ien_q == '0) |=> !irq);
endmodule

// File: rtl/dual_mailbox.sv
// Module: top of the dual-sided mailbox.
// Joins the shared data array with one register side per agent and forms
// each side's read data. Assumes ADDR_W covers every mapped offset.
module dual_mailbox #(
    parameter int NUM_BYTES = 16,
    parameter int ADDR_W    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           h_addr,
    input  logic                        h_wr,
    input  logic                        h_rd,
    input  logic [7:0]                  h_wdata,
    output logic [7:0]                  h_rdata,
    output logic                        h_irq,
    input  logic [ADDR_W-1:0]           m_addr,
    input  logic                        m_wr,
    input  logic                        m_rd,
    input  logic [7:0]                  m_wdata,
    output logic [7:0]                  m_rdata,
    output logic                        m_irq
);
    localparam int BW       = mbox_pkg::BYTE_W;
    localparam int IDX_W    = $clog2(NUM_BYTES);
    localparam int NSTAT    = NUM_BYTES / BW;
    localparam int M_CTRL   = NUM_BYTES + NSTAT;
    localparam int H_CTRL   = NUM_BYTES + NSTAT + 1;

    logic [NUM_BYTES*BW-1:0] bytes_flat;
    logic [NUM_BYTES-1:0]    h_hit, m_hit;
    logic                    h_is_data, m_is_data, h_touch, m_touch;
    logic                    h_ping, m_ping;
    logic [BW-1:0]           h_side_rd, m_side_rd;

    // Classify each side's access as a data-byte access or not.
    assign h_is_data = h_addr < ADDR_W'(NUM_BYTES);
    assign m_is_data = m_addr < ADDR_W'(NUM_BYTES);
    assign h_touch   = h_is_data && (h_wr || h_rd);
    assign m_touch   = m_is_data && (m_wr || m_rd);

    mbox_data_array #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_data (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
        .m_addr(m_addr), .m_wr(m_wr), .m_wdata(m_wdata),
        .bytes_flat(bytes_flat), .h_hit(h_hit), .m_hit(m_hit)
    );

    mbox_side #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .CTRL_OFS(H_CTRL)) u_host (
        .clk(clk), .rst_n(rst_n),
        .addr(h_addr), .wr(h_wr), .wdata(h_wdata),
        .peer_hit(m_hit), .peer_touch(m_touch), .peer_ping(m_ping),
        .rdata(h_side_rd), .ping_out(h_ping), .irq(h_irq)
    );

    mbox_side #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .CTRL_OFS(M_CTRL)) u_mgmt (
        .clk(clk), .rst_n(rst_n),
        .addr(m_addr), .wr(m_wr), .wdata(m_wdata),
        .peer_hit(h_hit), .peer_touch(h_touch), .peer_ping(h_ping),
        .rdata(m_side_rd), .ping_out(m_ping), .irq(m_irq)
    );

    // Read data: shared byte for data offsets, else the side's own register.
    assign h_rdata = h_is_data ? bytes_flat[h_addr[IDX_W-1:0]*BW +: BW] : h_side_rd;
    assign m_rdata = m_is_data ? bytes_flat[m_addr[IDX_W-1:0]*BW +: BW] : m_side_rd;

    // R1
    irq_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!h_irq && !m_irq));
endmodule

// File: tb/tb_dual_mailbox.sv
`timescale 1ns/1ps
module tb_dual_mailbox;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic [4:0] h_addr = '0, m_addr = '0;
    logic       h_wr = 0, h_rd = 0, m_wr = 0, m_rd = 0;
    logic [7:0] h_wdata = '0, m_wdata = '0;
    logic [7:0] h_rdata, m_rdata;
    logic       h_irq, m_irq;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] v;

    always #4 clk = ~clk;

    dual_mailbox dut (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_irq(h_irq),
        .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_irq(m_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1;
        @(negedge clk); h_wr = 0;
    endtask
    task automatic mw(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); m_addr = a; m_wdata = d; m_wr = 1;
        @(negedge clk); m_wr = 0;
    endtask
    task automatic bw(input logic [4:0] a, input logic [7:0] hd, input logic [7:0] md);
        @(negedge clk); h_addr = a; m_addr = a; h_wdata = hd; m_wdata = md; h_wr = 1; m_wr = 1;
        @(negedge clk); h_wr = 0; m_wr = 0;
    endtask
    task automatic mtouch(input logic [4:0] a);
        @(negedge clk); m_addr = a; m_rd = 1;
        @(negedge clk); m_rd = 0;
    endtask
    task automatic hchk(input string req, input logic [4:0] a, input logic [7:0] exp);
        @(negedge clk); h_addr = a; #1 check(req, h_rdata, exp);
    endtask
    task automatic mchk(input string req, input logic [4:0] a, input logic [7:0] exp);
        @(negedge clk); m_addr = a; #1 check(req, m_rdata, exp);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: every offset zero from both sides, interrupts low
        for (int a = 0; a < 32; a++) begin
            hchk("R1", 5'(a), 8'h00);
            mchk("R1", 5'(a), 8'h00);
        end
        check("R1 h_irq", {7'b0, h_irq}, 8'h00);
        check("R1 m_irq", {7'b0, m_irq}, 8'h00);

        // R2/R4/R5: sweep every byte in both directions
        for (int k = 0; k < 16; k++) begin
            logic [4:0] sr;
            logic [7:0] bit_k;
            sr    = 5'(16 + k / 8);
            bit_k = 8'(1 << (k % 8));
            v = 8'(k * 7 + 3);
            hw(5'(k), v);
            mchk("R2", 5'(k), v);
            hchk("R2", 5'(k), v);
            mchk("R4 peer flag", sr, bit_k);
            hchk("R4 writer flag", sr, 8'h00);
            mw(sr, 8'h00);
            mchk("R5 zero keeps", sr, bit_k);
            mw(sr, bit_k);
            mchk("R5 one clears", sr, 8'h00);
            mw(5'(k), ~v);
            hchk("R2", 5'(k), ~v);
            hchk("R4 peer flag", sr, bit_k);
            mchk("R4 writer flag", sr, 8'h00);
            hw(sr, bit_k);
            hchk("R5 one clears", sr, 8'h00);
        end

        // R3: simultaneous write of byte 13
        bw(5'd13, 8'h11, 8'hEE);
        hchk("R3 value", 5'd13, 8'hEE);
        mchk("R3 value", 5'd13, 8'hEE);
        hchk("R3 host flag", 5'h11, 8'h20);
        mchk("R3 mgmt flag", 5'h11, 8'h20);

        // Clean slate: clear flags and coarse status, mask both sides
        hw(5'h10, 8'hFF); hw(5'h11, 8'hFF);
        mw(5'h10, 8'hFF); mw(5'h11, 8'hFF);
        hw(5'h13, 8'h82); mw(5'h12, 8'h82);

        // R6/R10: only response and attention bytes interrupt the host
        hw(5'h15, 8'hA0);
        hchk("R6 enable readback", 5'h15, 8'hA0);
        for (int k = 8; k < 16; k++) begin
            mw(5'(k), 8'(k));
            check("R10 not yet", {7'b0, h_irq}, 8'h00);
            @(negedge clk);
            check("R6 irq", {7'b0, h_irq}, (k == 13 || k == 15) ? 8'h01 : 8'h00);
            hw(5'h11, 8'(1 << (k - 8)));
            @(negedge clk);
            check("R5 irq after clear", {7'b0, h_irq}, 8'h00);
        end

        // R7/R8: coarse status from a peer read
        hw(5'h15, 8'h00);
        hw(5'h13, 8'h80);
        @(negedge clk);
        check("R8 cleared", {7'b0, h_irq}, 8'h00);
        mtouch(5'd2);
        hchk("R7 coarse set", 5'h13, 8'h80);
        check("R8 unmasked irq", {7'b0, h_irq}, 8'h01);
        hw(5'h13, 8'h02);
        @(negedge clk);
        check("R8 masked irq", {7'b0, h_irq}, 8'h00);
        hchk("R8 status kept", 5'h13, 8'h82);
        hw(5'h13, 8'h82);
        hchk("R7 W1C", 5'h13, 8'h02);

        // R9: ping with mask in one write
        mw(5'h12, 8'h82);
        hw(5'h13, 8'h03);
        mchk("R9 peer coarse", 5'h12, 8'h82);
        hchk("R9 own masked, ping reads 0", 5'h13, 8'h02);
        check("R9 masked peer irq", {7'b0, m_irq}, 8'h00);
        mw(5'h12, 8'h00);
        @(negedge clk);
        check("R9 peer irq", {7'b0, m_irq}, 8'h01);
        mchk("R9 status kept", 5'h12, 8'h80);

        // R11: foreign control offset and unmapped offsets
        hw(5'h12, 8'hFF);
        mchk("R11 mgmt ctrl untouched", 5'h12, 8'h80);
        hchk("R11 foreign ctrl reads 0", 5'h12, 8'h00);
        mw(5'h13, 8'hFF);
        hchk("R11 host ctrl untouched", 5'h13, 8'h02);
        for (int a = 22; a < 32; a++) begin
            hw(5'(a), 8'hFF);
            hchk("R11 unmapped", 5'(a), 8'h00);
        end
        finish_run();
    end
endmodule